// File: doc/BRIEF.md
# DRAM Open-Row Tracker and Refresh Row Source

This block sits beside a DRAM controller's sequencer and answers one question for every new transfer: does the requested row match the row that is already open in the memory? It keeps the most recently opened row and a valid bit. On each transfer-start strobe it compares the row field of the incoming address with that stored row. One clock later it presents the answer on an active-low hit flag. It also drives a row/column phase indication that the sequencer uses to choose between opening a row and issuing a column access.

The block also supplies the row addresses for refresh. A free-running row counter appears on the memory address output while the active-low refresh select is held low. The counter steps to the next row when refresh select is released. Any non-memory transfer (I/O or configuration) and any refresh invalidates the stored row, so the access that follows is always treated as a miss. The controller may still handle that access as a forced page condition of its own.

Top module: `dram_page_unit`

## Requirements
- R1: After reset, `page_hit_n_o` is 1, `ras_phase_o` is 0, `mem_addr_o` is 0 and the refresh row counter is 0.
- R2: `page_hit_n_o` changes only at the clock edge that samples `start_i` high, so it is valid exactly one clock after the strobe. It holds its value until the next strobe.
- R3: A strobe with `nonmem_i` low reports a hit (`page_hit_n_o` = 0) only when a stored row is valid and address bits [ROW_LSB+ROW_W-1:ROW_LSB] equal it. Address bits outside that field have no effect on the result.
- R4: The first memory transfer after reset is reported as a miss.
- R5: A memory transfer that misses stores its row and marks it valid, so a following transfer to the same row is reported as a hit.
- R6: A strobe with `nonmem_i` high (I/O or configuration cycle) reports no hit and invalidates the stored row. The next memory transfer then misses, even when it targets the same row.
- R7: Any clock in which `refresh_sel_n_i` is low invalidates the stored row. The next memory transfer then misses.
- R8: While `refresh_sel_n_i` is low, `mem_addr_o` equals the refresh row counter. Otherwise it equals the row field of the most recent strobe.
- R9: The refresh row counter increments by one at the clock edge that samples `refresh_sel_n_i` back high after a low sample. It wraps from all ones to zero.
- R10: `ras_phase_o` is 1 (row phase) while `refresh_sel_n_i` is low. It is also 1 for the one clock that follows a strobe that missed or had `nonmem_i` high. It is 0 (column phase) otherwise, including the clock after a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Transfer-start strobe, one clock wide |
| addr_i | input | ADDR_W | Transfer address; the row field is extracted inside |
| nonmem_i | input | 1 | Strobe qualifier: I/O or configuration cycle |
| refresh_sel_n_i | input | 1 | Active-low refresh select |
| page_hit_n_o | output | 1 | Active-low same-row flag, registered |
| mem_addr_o | output | ROW_W | Row address toward the DRAM address mux |
| ras_phase_o | output | 1 | 1 = row phase, 0 = column phase |

## Verification
The bench targets three failure modes. The first is the first transfer after reset: a design that trusts a zeroed row register without a valid bit reports a false hit there. The second is a same-row transfer after an I/O cycle or a refresh: a design that forgets to invalidate reports a hit that would skip the row open. The third is an address that differs only outside the row field: a wrong field slice turns real hits into misses, or the reverse. The refresh counter is stepped past its full range to catch a counter that advances on the falling edge or fails to wrap. The bench also checks the phase flag, which must fall in the clock after a hit and must not stay high.

// File: rtl/dram_row_pkg.sv
package dram_row_pkg;

   typedef enum logic {
      PH_COL = 1'b0,
      PH_ROW = 1'b1
   } phase_e;

   function automatic int unsigned slice_count(input int unsigned row_w,
                                               input int unsigned slice_w);
      return row_w / slice_w;
   endfunction

endpackage

// File: rtl/drpt_row_cmp.sv
module drpt_row_cmp #(
   parameter int unsigned ROW_W   = 12,
   parameter int unsigned SLICE_W = 4
) (
   input  logic [ROW_W-1:0] a_i,
   input  logic [ROW_W-1:0] b_i,
   output logic             eq_o
);
   localparam int unsigned NSL = dram_row_pkg::slice_count(ROW_W, SLICE_W);

   generate
      if (SLICE_W >= ROW_W) begin : g_flat
         assign eq_o = (a_i == b_i);
      end else begin : g_sliced
         logic [NSL-1:0] sl_eq;
         for (genvar g = 0; g < NSL; g++) begin : g_sl
            assign sl_eq[g] = (a_i[g*SLICE_W +: SLICE_W] == b_i[g*SLICE_W +: SLICE_W]);
         end
         assign eq_o = &sl_eq;
      end
   endgenerate

endmodule

// File: rtl/drpt_open_row.sv
module drpt_open_row #(
   parameter int unsigned ROW_W   = 12,
   parameter int unsigned SLICE_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [ROW_W-1:0] row_i,
   input  logic             nonmem_i,
   input  logic             inval_i,
   output logic             hit_n_o,
   output logic             row_phase_o,
   output logic [ROW_W-1:0] txn_row_o
);
   import dram_row_pkg::*;

   logic [ROW_W-1:0] open_row_q;
   logic             open_vld_q;
   logic             row_eq;
   logic             hit;
   phase_e           phase_q;

   drpt_row_cmp #(
      .ROW_W   (ROW_W),
      .SLICE_W (SLICE_W)
   ) u_cmp (
      .a_i  (row_i),
      .b_i  (open_row_q),
      .eq_o (row_eq)
   );

   assign hit = open_vld_q & row_eq & ~nonmem_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_row_q <= '0;
         open_vld_q <= 1'b0;
         hit_n_o    <= 1'b1;
         phase_q    <= PH_COL;
         txn_row_o  <= '0;
      end else begin
         phase_q <= PH_COL;
         if (start_i) begin
            hit_n_o   <= ~hit;
            txn_row_o <= row_i;
            phase_q   <= hit ? PH_COL : PH_ROW;
            if (nonmem_i) begin
               open_vld_q <= 1'b0;
            end else if (!hit) begin
               open_row_q <= row_i;
               open_vld_q <= 1'b1;
            end
         end
         if (inval_i) begin
            open_vld_q <= 1'b0;
         end
      end
   end

   assign row_phase_o = (phase_q == PH_ROW);

endmodule

// File: rtl/drpt_refresh_ctr.sv
module drpt_refresh_ctr #(
   parameter int unsigned ROW_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_n_i,
   output logic [ROW_W-1:0] row_o
);
   logic sel_n_q;
   logic release_edge;

   assign release_edge = sel_n_i & ~sel_n_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_n_q <= 1'b1;
         row_o   <= '0;
      end else begin
         sel_n_q <= sel_n_i;
         if (release_edge) begin
            row_o <= row_o + 1'b1;
         end
      end
   end

endmodule

// File: rtl/dram_page_unit.sv
module dram_page_unit #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned ROW_W   = 12,
   parameter int unsigned ROW_LSB = 11,
   parameter int unsigned SLICE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              nonmem_i,
   input  logic              refresh_sel_n_i,
   output logic              page_hit_n_o,
   output logic [ROW_W-1:0]  mem_addr_o,
   output logic              ras_phase_o
);
   localparam int unsigned ROW_MSB = ROW_LSB + ROW_W - 1;

   generate
      if (ROW_MSB >= ADDR_W) begin : g_bad_field
         $error("dram_page_unit: row field exceeds address width");
      end
      if (SLICE_W == 0 || (SLICE_W < ROW_W && (ROW_W % SLICE_W) != 0)) begin : g_bad_slice
         $error("dram_page_unit: SLICE_W must divide ROW_W");
      end
   endgenerate

   logic [ROW_W-1:0] row_fld;
   logic [ROW_W-1:0] txn_row;
   logic [ROW_W-1:0] ref_row;
   logic             row_phase;
   logic             refresh_on;

   assign row_fld    = addr_i[ROW_MSB:ROW_LSB];
   assign refresh_on = ~refresh_sel_n_i;

   drpt_open_row #(
      .ROW_W   (ROW_W),
      .SLICE_W (SLICE_W)
   ) u_row (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .row_i       (row_fld),
      .nonmem_i    (nonmem_i),
      .inval_i     (refresh_on),
      .hit_n_o     (page_hit_n_o),
      .row_phase_o (row_phase),
      .txn_row_o   (txn_row)
   );

   drpt_refresh_ctr #(
      .ROW_W (ROW_W)
   ) u_ref (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_n_i (refresh_sel_n_i),
      .row_o   (ref_row)
   );

   assign mem_addr_o  = refresh_on ? ref_row : txn_row;
   assign ras_phase_o = row_phase | refresh_on;

endmodule

// File: rtl/dram_page_unit_chk.sv
module dram_page_unit_chk #(
   parameter int unsigned ROW_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             nonmem_i,
   input logic             refresh_sel_n_i,
   input logic             page_hit_n_o,
   input logic [ROW_W-1:0] mem_addr_o,
   input logic             ras_phase_o
);

   assert_hit_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> $stable(page_hit_n_o));

   assert_nonmem_no_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && nonmem_i) |=> page_hit_n_o);

   assert_refresh_then_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !refresh_sel_n_i ##1 (start_i && !nonmem_i) |=> page_hit_n_o);

   assert_ref_addr_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !refresh_sel_n_i ##1 !refresh_sel_n_i |-> $stable(mem_addr_o));

   assert_row_phase_refresh_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !refresh_sel_n_i |-> ras_phase_o);

   assert_hit_is_column_R10: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_sel_n_i && !page_hit_n_o && $past(start_i) |-> !ras_phase_o);

endmodule

bind dram_page_unit dram_page_unit_chk #(.ROW_W(ROW_W)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .start_i         (start_i),
   .nonmem_i        (nonmem_i),
   .refresh_sel_n_i (refresh_sel_n_i),
   .page_hit_n_o    (page_hit_n_o),
   .mem_addr_o      (mem_addr_o),
   .ras_phase_o     (ras_phase_o)
);

// File: tb/sim_dram_page_unit.sv
`timescale 1ns/1ps
module sim_dram_page_unit;
   localparam int unsigned ADDR_W  = 32;
   localparam int unsigned ROW_W   = 12;
   localparam int unsigned ROW_LSB = 11;
   localparam int unsigned WD_MAX  = 150000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic              nonmem = 1'b0;
   logic              ref_n = 1'b1;
   logic              hit_n;
   logic [ROW_W-1:0]  maddr;
   logic              ras;

   int unsigned n_run = 0;
   int unsigned n_fail = 0;
   int unsigned cyc_cnt = 0;
   bit          done = 1'b0;

   // reference model state
   logic [ROW_W-1:0] m_open = '0;
   logic             m_vld = 1'b0;
   logic [ROW_W-1:0] m_txn = '0;
   logic [ROW_W-1:0] m_cnt = '0;
   logic             m_prev = 1'b1;
   logic             m_hitn = 1'b1;
   logic             m_rasq = 1'b0;

   always #4 clk = ~clk;

   dram_page_unit #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .ROW_LSB(ROW_LSB), .SLICE_W(4)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr), .nonmem_i(nonmem),
      .refresh_sel_n_i(ref_n), .page_hit_n_o(hit_n), .mem_addr_o(maddr), .ras_phase_o(ras)
   );

   function automatic logic [ADDR_W-1:0] mk(input logic [ROW_W-1:0] row, input logic [ADDR_W-1:0] junk);
      logic [ADDR_W-1:0] mask;
      mask = {{(ADDR_W-ROW_W){1'b0}}, {ROW_W{1'b1}}} << ROW_LSB;
      return (junk & ~mask) | ({{(ADDR_W-ROW_W){1'b0}}, row} << ROW_LSB);
   endfunction

   function automatic logic [ROW_W-1:0] exp_addr(input logic rn, input logic [ROW_W-1:0] cnt,
                                                 input logic [ROW_W-1:0] txn);
      return rn ? txn : cnt;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_edge();
      logic [ROW_W-1:0] r;
      logic h;
      r = addr[ROW_LSB +: ROW_W];
      m_rasq = 1'b0;
      if (start) begin
         h = m_vld && (r == m_open) && !nonmem;
         m_hitn = !h;
         m_rasq = !h;
         m_txn = r;
         if (nonmem) m_vld = 1'b0;
         else if (!h) begin m_open = r; m_vld = 1'b1; end
      end
      if (!ref_n) m_vld = 1'b0;
      if (!m_prev && ref_n) m_cnt = m_cnt + 1'b1;
      m_prev = ref_n;
   endtask

   task automatic cyc(input logic st, input logic [ADDR_W-1:0] a, input logic nm, input logic rn);
      @(negedge clk);
      start = st; addr = a; nonmem = nm; ref_n = rn;
      @(posedge clk);
      model_edge();
      #2;
      chk("R2/R3 hit flag", {31'b0, hit_n}, {31'b0, m_hitn});
      chk("R10 phase", {31'b0, ras}, {31'b0, m_rasq | ~rn});
      chk("R8 mem addr", {20'b0, maddr}, {20'b0, exp_addr(rn, m_cnt, m_txn)});
   endtask

   always @(posedge clk) begin
      cyc_cnt <= cyc_cnt + 1;
      if (cyc_cnt == WD_MAX && !done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog actual=%0d expected<%0d", cyc_cnt, WD_MAX);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [ROW_W-1:0] pool [4];
      void'($urandom(32'd4177));
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      // R1: reset state
      chk("R1 hit_n", {31'b0, hit_n}, 32'd1);
      chk("R1 ras", {31'b0, ras}, 32'd0);
      chk("R1 addr", {20'b0, maddr}, 32'd0);

      // R4: first access misses
      cyc(1, mk(12'h005, 32'hA5A5_A5A5), 0, 1);
      chk("R4 first miss", {31'b0, hit_n}, 32'd1);
      cyc(0, '0, 0, 1);
      // R5 + R3: same row, different bits outside the field
      cyc(1, mk(12'h005, 32'h5A5A_5A5A), 0, 1);
      chk("R5 same row hit", {31'b0, hit_n}, 32'd0);
      chk("R3 outside bits ignored", {31'b0, hit_n}, 32'd0);
      cyc(0, '0, 0, 1);
      chk("R10 column after hit", {31'b0, ras}, 32'd0);
      cyc(1, mk(12'h800, '0), 0, 1);
      chk("R3 row msb differs", {31'b0, hit_n}, 32'd1);
      cyc(1, mk(12'h800, 32'hFFFF_FFFF), 0, 1);
      chk("R5 hit", {31'b0, hit_n}, 32'd0);
      // R6: non-memory cycle
      cyc(1, mk(12'h800, '0), 1, 1);
      chk("R6 nonmem no hit", {31'b0, hit_n}, 32'd1);
      chk("R6 nonmem row phase", {31'b0, ras}, 32'd1);
      cyc(1, mk(12'h800, '0), 0, 1);
      chk("R6 next access miss", {31'b0, hit_n}, 32'd1);
      cyc(1, mk(12'h800, '0), 0, 1);
      // R7: refresh invalidates
      cyc(0, '0, 0, 0);
      chk("R8 refresh row", {20'b0, maddr}, 32'd0);
      cyc(0, '0, 0, 1);
      cyc(1, mk(12'h800, '0), 0, 1);
      chk("R7 miss after refresh", {31'b0, hit_n}, 32'd1);
      cyc(0, '0, 0, 0);
      chk("R9 counter stepped", {20'b0, maddr}, 32'd1);
      cyc(0, '0, 0, 1);

      // constrained random
      for (int k = 0; k < 4; k++) pool[k] = 12'($urandom);
      for (int i = 0; i < 3000; i++) begin
         int unsigned d;
         d = $urandom_range(0, 99);
         if (d < 8) begin
            for (int j = 0; j < int'($urandom_range(1, 3)); j++) cyc(0, 32'($urandom), 0, 0);
            cyc(0, 32'($urandom), 0, 1);
         end else begin
            cyc(d < 70, mk(pool[$urandom_range(0, 3)], 32'($urandom)), d > 88, 1);
         end
      end

      // R9: run the counter around its full range
      while (m_cnt != {ROW_W{1'b1}}) begin
         cyc(0, '0, 0, 0);
         cyc(0, '0, 0, 1);
      end
      cyc(0, '0, 0, 0);
      chk("R9 all ones", {20'b0, maddr}, {20'b0, {ROW_W{1'b1}}});
      cyc(0, '0, 0, 1);
      cyc(0, '0, 0, 0);
      chk("R9 wrap to zero", {20'b0, maddr}, 32'd0);
      cyc(0, '0, 0, 1);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule